// File: doc/BRIEF.md
# Flash Command Status and Interrupt Unit

This block holds the host-visible command, configuration, error-status and interrupt registers of a flash controller's host interface. Software writes 16-bit values into these registers over a simple write port and reads any of them back through a combinational read port. When software writes an opcode, the block passes it to a separate command sequencer as a one-cycle start pulse. It passes an opcode on only when the previous command has been acknowledged, which means the master done flag in the interrupt register is clear.

When a command finishes, the sequencer reports it with a completion pulse. The pulse carries a kind (plain, erase, program or load) and an error flag. The sequencer also has a separate pulse for an opcode it does not recognise. The block turns these events into interrupt and error bits. Software acknowledges them by writing an AND mask into the interrupt register. The interrupt output level is the master done flag, with its polarity set by a configuration bit. A ready output is loaded from another configuration bit. The flash array, the data buffers and the execution of commands all sit outside this block.

The block has two reset sources. The asynchronous `rst_n` is the cold reset. The synchronous `warm_rst` pulse is a warm reset that the sequencer raises when it runs a reset command.

Top module: `flash_cmd_status`

## Requirements
- R1: After cold reset, the registers hold these values: command 0x0000, configuration 1 0x40C0, configuration 2 0x0000, status 0x0000 and interrupt 0x8080. `rdy` is 1 and `cmd_go` is 0.
- R2: A `warm_rst` pulse sets interrupt to 0x8010 and status, command and configuration 2 to 0x0000. It sets configuration 1 to 0x40C0 and `rdy` to 1. It has priority over every write and event in the same cycle.
- R3: A write to the interrupt register (address 4) replaces the register with its old value ANDed with the written data.
- R4: Status bits 10 (command error), 11 (erase error), 12 (program error) and 13 (load error) are cleared when an interrupt write leaves bit 15 clear after the AND. An interrupt write that leaves bit 15 set keeps those bits.
- R5: A write to the command register (address 0) is ignored while interrupt bit 15 is set. Otherwise the register stores the opcode, and one cycle later `cmd_go` pulses high for one cycle while `cmd_op` shows the opcode.
- R6: A `done_pulse` sets interrupt bit 15 and a bit chosen by `done_kind`: 0 plain (no extra bit), 1 erase (bit 5), 2 program (bit 6) or 3 load (bit 7). If `done_err` is also high, the pulse sets status bit 10 and the matching error bit: none for plain, 11 for erase, 12 for program, 13 for load.
- R7: A `bad_opcode` pulse sets status bit 10 and interrupt bit 15.
- R8: `irq` equals interrupt bit 15 XOR the inverse of configuration-1 bit 6.
- R9: Reading configuration 1 (address 1) returns the stored value ANDed with 0xFFE0. Reading configuration 2 (address 2) returns the whole stored value.
- R10: Every write to configuration 1 loads `rdy` with bit 7 of the written data.
- R11: When an interrupt write and completion events fall in the same cycle, the AND mask and the error clear are applied first. The new interrupt and error bits are then ORed in.
- R12: Read addresses are 0 command, 1 configuration 1, 2 configuration 2, 3 status and 4 interrupt. Addresses 5 to 7 read 0x0000. Writes to address 3 or to addresses 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| warm_rst | input | 1 | Synchronous warm reset pulse |
| done_pulse | input | 1 | Command completion pulse from sequencer |
| done_kind | input | 2 | Completion kind: plain, erase, program, load |
| done_err | input | 1 | The completing command failed |
| bad_opcode | input | 1 | Sequencer rejected the opcode |
| cmd_go | output | 1 | One-cycle start pulse for an accepted command |
| cmd_op | output | 16 | Accepted opcode |
| irq | output | 1 | Interrupt level with configurable polarity |
| rdy | output | 1 | Ready level from configuration-1 bit 7 |

## Verification
Each register write, completion pulse, opcode rejection and warm reset is taken at one rising edge. It is visible on `rd_data`, `irq` and `rdy` from that edge onwards, so each result is due one edge after its stimulus. `cmd_go` rises at the same edge as the accepted command write and falls at the next edge. The bench drives every stimulus just after a falling edge and holds it across exactly one rising edge. It samples at the following falling edge, and samples `cmd_go` again one cycle later to confirm the pulse has ended. Interrupt AND masks, completion kinds with and without errors, polarity settings and configuration values are swept, each with expected words built by arithmetic from the bit positions in the requirements.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CMD  = 3'd0,
    SEL_CFG1 = 3'd1,
    SEL_CFG2 = 3'd2,
    SEL_STAT = 3'd3,
    SEL_INTR = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    DONE_PLAIN = 2'd0,
    DONE_ERASE = 2'd1,
    DONE_PROG  = 2'd2,
    DONE_LOAD  = 2'd3
  } done_kind_e;

  // interrupt register bit positions
  localparam int INT_MASTER = 15;
  localparam int INT_RESET  = 4;
  localparam int INT_ERASE  = 5;
  localparam int INT_PROG   = 6;
  localparam int INT_LOAD   = 7;

  // status register error bit positions
  localparam int ERR_CMD   = 10;
  localparam int ERR_ERASE = 11;
  localparam int ERR_PROG  = 12;
  localparam int ERR_LOAD  = 13;

  // configuration 1 bit positions
  localparam int CFG_POL = 6;
  localparam int CFG_RDY = 7;

  localparam logic [REG_W-1:0] CFG1_INIT    = 16'h40C0;
  localparam logic [REG_W-1:0] CFG1_RD_MASK = 16'hFFE0;
  localparam logic [REG_W-1:0] INTR_COLD    = (16'h1 << INT_MASTER) | (16'h1 << INT_LOAD);
  localparam logic [REG_W-1:0] INTR_WARM    = (16'h1 << INT_MASTER) | (16'h1 << INT_RESET);
  localparam logic [REG_W-1:0] ERR_ALL      = (16'h1 << ERR_CMD) | (16'h1 << ERR_ERASE) |
                                              (16'h1 << ERR_PROG) | (16'h1 << ERR_LOAD);

  function automatic logic [REG_W-1:0] kind_int_bit(input done_kind_e k);
    logic [REG_W-1:0] v;
    v = '0;
    case (k)
      DONE_ERASE: v[INT_ERASE] = 1'b1;
      DONE_PROG:  v[INT_PROG]  = 1'b1;
      DONE_LOAD:  v[INT_LOAD]  = 1'b1;
      default:    v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [REG_W-1:0] kind_err_bit(input done_kind_e k);
    logic [REG_W-1:0] v;
    v = '0;
    case (k)
      DONE_ERASE: v[ERR_ERASE] = 1'b1;
      DONE_PROG:  v[ERR_PROG]  = 1'b1;
      DONE_LOAD:  v[ERR_LOAD]  = 1'b1;
      default:    v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/fcs_cfg_regs.sv
module fcs_cfg_regs
  import fcs_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         warm_rst,
  input  logic         cfg1_wr,
  input  logic         cfg2_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cfg1_q,
  output logic [W-1:0] cfg2_q,
  output logic         rdy_q
);

  logic [W-1:0] cfg1_d, cfg2_d;
  logic         rdy_d;
  logic         cfg_en;

  always_comb begin
    cfg_en = warm_rst | cfg1_wr | cfg2_wr;
    cfg1_d = cfg1_q;
    cfg2_d = cfg2_q;
    rdy_d  = rdy_q;
    if (warm_rst) begin
      cfg1_d = W'(CFG1_INIT);
      cfg2_d = '0;
      rdy_d  = 1'b1;
    end else begin
      if (cfg1_wr) begin
        cfg1_d = wr_data;
        rdy_d  = wr_data[CFG_RDY];
      end
      if (cfg2_wr) begin
        cfg2_d = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= W'(CFG1_INIT);
      cfg2_q <= '0;
      rdy_q  <= 1'b1;
    end else if (cfg_en) begin
      cfg1_q <= cfg1_d;
      cfg2_q <= cfg2_d;
      rdy_q  <= rdy_d;
    end
  end

endmodule

// File: rtl/fcs_event_regs.sv
module fcs_event_regs
  import fcs_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         warm_rst,
  input  logic         intr_wr,
  input  logic [W-1:0] wr_data,
  input  logic         done_pulse,
  input  logic [1:0]   done_kind,
  input  logic         done_err,
  input  logic         bad_opcode,
  output logic [W-1:0] intr_q,
  output logic [W-1:0] status_q
);

  logic [W-1:0] intr_masked;
  logic [W-1:0] status_base;
  logic [W-1:0] int_set;
  logic [W-1:0] err_set;
  logic [W-1:0] intr_d, status_d;
  logic         ev_en;

  // software acknowledge is applied first
  always_comb begin
    intr_masked = intr_wr ? (intr_q & wr_data) : intr_q;
    status_base = status_q;
    if (intr_wr && !intr_masked[INT_MASTER]) begin
      status_base = status_q & ~W'(ERR_ALL);
    end
  end

  // new events are merged on top of the acknowledged value
  always_comb begin
    int_set = '0;
    err_set = '0;
    if (done_pulse) begin
      int_set[INT_MASTER] = 1'b1;
      int_set = int_set | W'(kind_int_bit(done_kind_e'(done_kind)));
      if (done_err) begin
        err_set[ERR_CMD] = 1'b1;
        err_set = err_set | W'(kind_err_bit(done_kind_e'(done_kind)));
      end
    end
    if (bad_opcode) begin
      int_set[INT_MASTER] = 1'b1;
      err_set[ERR_CMD]    = 1'b1;
    end
  end

  always_comb begin
    ev_en = warm_rst | intr_wr | done_pulse | bad_opcode;
    if (warm_rst) begin
      intr_d   = W'(INTR_WARM);
      status_d = '0;
    end else begin
      intr_d   = intr_masked | int_set;
      status_d = status_base | err_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_q   <= W'(INTR_COLD);
      status_q <= '0;
    end else if (ev_en) begin
      intr_q   <= intr_d;
      status_q <= status_d;
    end
  end

endmodule

// File: rtl/fcs_cmd_gate.sv
module fcs_cmd_gate
  import fcs_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         warm_rst,
  input  logic         cmd_wr,
  input  logic         busy,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] command_q,
  output logic         go_q
);

  logic         accept;
  logic         cmd_en;
  logic [W-1:0] command_d;

  always_comb begin
    accept    = cmd_wr & ~busy & ~warm_rst;
    cmd_en    = accept | warm_rst;
    command_d = warm_rst ? '0 : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      command_q <= '0;
    end else if (cmd_en) begin
      command_q <= command_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q <= 1'b0;
    end else begin
      go_q <= accept;
    end
  end

endmodule

// File: rtl/fcs_read_mux.sv
module fcs_read_mux
  import fcs_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  command_q,
  input  logic [W-1:0]  cfg1_q,
  input  logic [W-1:0]  cfg2_q,
  input  logic [W-1:0]  status_q,
  input  logic [W-1:0]  intr_q,
  output logic [W-1:0]  rd_data
);

  always_comb begin
    case (rd_addr)
      SEL_CMD:  rd_data = command_q;
      SEL_CFG1: rd_data = cfg1_q & W'(CFG1_RD_MASK);
      SEL_CFG2: rd_data = cfg2_q;
      SEL_STAT: rd_data = status_q;
      SEL_INTR: rd_data = intr_q;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import fcs_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          warm_rst,
  input  logic          done_pulse,
  input  logic [1:0]    done_kind,
  input  logic          done_err,
  input  logic          bad_opcode,
  output logic          cmd_go,
  output logic [W-1:0]  cmd_op,
  output logic          irq,
  output logic          rdy
);

  logic         cmd_wr, cfg1_wr, cfg2_wr, intr_wr;
  logic [W-1:0] command_q, cfg1_q, cfg2_q, status_q, intr_q;
  logic         rdy_q, go_q;

  always_comb begin
    cmd_wr  = wr_en && (wr_addr == SEL_CMD);
    cfg1_wr = wr_en && (wr_addr == SEL_CFG1);
    cfg2_wr = wr_en && (wr_addr == SEL_CFG2);
    intr_wr = wr_en && (wr_addr == SEL_INTR);
  end

  fcs_cfg_regs #(.W(W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .warm_rst(warm_rst),
    .cfg1_wr (cfg1_wr),
    .cfg2_wr (cfg2_wr),
    .wr_data (wr_data),
    .cfg1_q  (cfg1_q),
    .cfg2_q  (cfg2_q),
    .rdy_q   (rdy_q)
  );

  fcs_event_regs #(.W(W)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm_rst  (warm_rst),
    .intr_wr   (intr_wr),
    .wr_data   (wr_data),
    .done_pulse(done_pulse),
    .done_kind (done_kind),
    .done_err  (done_err),
    .bad_opcode(bad_opcode),
    .intr_q    (intr_q),
    .status_q  (status_q)
  );

  fcs_cmd_gate #(.W(W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .warm_rst (warm_rst),
    .cmd_wr   (cmd_wr),
    .busy     (intr_q[INT_MASTER]),
    .wr_data  (wr_data),
    .command_q(command_q),
    .go_q     (go_q)
  );

  fcs_read_mux #(.W(W), .AW(AW)) u_rd (
    .rd_addr  (rd_addr),
    .command_q(command_q),
    .cfg1_q   (cfg1_q),
    .cfg2_q   (cfg2_q),
    .status_q (status_q),
    .intr_q   (intr_q),
    .rd_data  (rd_data)
  );

  assign cmd_go = go_q;
  assign cmd_op = command_q;
  assign rdy    = rdy_q;
  assign irq    = intr_q[INT_MASTER] ^ ~cfg1_q[CFG_POL];

endmodule

// File: rtl/fcs_chk.sv
module fcs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        warm_rst,
  input logic        done_pulse,
  input logic        bad_opcode,
  input logic        cmd_go,
  input logic        rdy,
  input logic [15:0] intr_q,
  input logic [15:0] status_q,
  input logic [15:0] command_q
);

  // R5
  refused_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0 && intr_q[15] && !warm_rst) |=> (!cmd_go && $stable(command_q)));

  // R5
  go_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> $past(wr_en && wr_addr == 3'd0 && !intr_q[15] && !warm_rst));

  // R4
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4 && !wr_data[15] && !done_pulse && !bad_opcode && !warm_rst)
    |=> (status_q[13:10] == 4'h0));

  // R3
  and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4 && !done_pulse && !bad_opcode && !warm_rst)
    |=> ((intr_q & ~$past(intr_q)) == 16'h0000));

  // R6
  done_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && !warm_rst) |=> intr_q[15]);

  // R7
  bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_opcode && !warm_rst) |=> (intr_q[15] && status_q[10]));

  // R2
  warm_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (intr_q == 16'h8010 && status_q == 16'h0000 && rdy));

  // R10
  rdy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1 && !warm_rst) |=> (rdy == $past(wr_data[7])));

endmodule

bind flash_cmd_status fcs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .warm_rst  (warm_rst),
  .done_pulse(done_pulse),
  .bad_opcode(bad_opcode),
  .cmd_go    (cmd_go),
  .rdy       (rdy),
  .intr_q    (intr_q),
  .status_q  (status_q),
  .command_q (command_q)
);

// File: tb/tb_flash_cmd_status.sv
module tb_flash_cmd_status;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic        warm_rst;
  logic        done_pulse;
  logic [1:0]  done_kind;
  logic        done_err;
  logic        bad_opcode;
  logic        cmd_go;
  logic [15:0] cmd_op;
  logic        irq;
  logic        rdy;

  int checks;
  int failures;
  bit finished;

  flash_cmd_status dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .warm_rst  (warm_rst),
    .done_pulse(done_pulse),
    .done_kind (done_kind),
    .done_err  (done_err),
    .bad_opcode(bad_opcode),
    .cmd_go    (cmd_go),
    .cmd_op    (cmd_op),
    .irq       (irq),
    .rdy       (rdy)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // all drive tasks start and end just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic done(input int k, input bit e);
    done_kind  = 2'(k);
    done_err   = e;
    done_pulse = 1'b1;
    @(negedge clk);
    done_pulse = 1'b0;
    done_err   = 1'b0;
  endtask

  function automatic logic [15:0] kint(input int k);
    return (k == 0) ? 16'h0000 : (16'h1 << (4 + k));
  endfunction

  function automatic logic [15:0] kerr(input int k);
    return (k == 0) ? 16'h0000 : (16'h1 << (10 + k));
  endfunction

  // intr = 0x80E0, status = 0x3C00
  task automatic load_all();
    wr(3'd4, 16'h0000);
    done(1, 1'b1);
    done(2, 1'b1);
    done(3, 1'b1);
  endtask

  initial begin
    logic [15:0] d;
    logic [15:0] snap_c, snap_1, snap_2, snap_s, snap_i;
    checks = 0; failures = 0; finished = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    warm_rst = 1'b0; done_pulse = 1'b0; done_kind = '0; done_err = 1'b0; bad_opcode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 cold reset state
    rd(3'd0, d); chk("R1 command", d, 16'h0000);
    rd(3'd1, d); chk("R1 cfg1", d, 16'h40C0);
    rd(3'd2, d); chk("R1 cfg2", d, 16'h0000);
    rd(3'd3, d); chk("R1 status", d, 16'h0000);
    rd(3'd4, d); chk("R1 intr", d, 16'h8080);
    chk("R1 rdy", {15'd0, rdy}, 16'h0001);
    chk("R1 cmd_go", {15'd0, cmd_go}, 16'h0000);
    chk("R8 irq after reset", {15'd0, irq}, 16'h0001);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); chk("R12 unused read", d, 16'h0000);
    end

    // R5 refused while bit 15 set
    wr(3'd0, 16'h0094);
    chk("R5 refused go", {15'd0, cmd_go}, 16'h0000);
    rd(3'd0, d); chk("R5 refused command", d, 16'h0000);

    // R3 clear and R5 accepted command
    wr(3'd4, 16'h0000);
    rd(3'd4, d); chk("R3 clear intr", d, 16'h0000);
    wr(3'd0, 16'h0080);
    chk("R5 go pulse", {15'd0, cmd_go}, 16'h0001);
    chk("R5 cmd_op", cmd_op, 16'h0080);
    @(negedge clk);
    chk("R5 go ends", {15'd0, cmd_go}, 16'h0000);
    rd(3'd0, d); chk("R5 command readback", d, 16'h0080);

    // R6 completion kinds with and without error
    for (int k = 0; k < 4; k++) begin
      for (int e = 0; e < 2; e++) begin
        wr(3'd4, 16'h0000);
        done(k, e[0]);
        rd(3'd4, d); chk("R6 intr bits", d, 16'h8000 | kint(k));
        rd(3'd3, d); chk("R6 status bits", d, (e != 0) ? (16'h0400 | kerr(k)) : 16'h0000);
      end
    end

    // R7 bad opcode, then command refused
    wr(3'd4, 16'h0000);
    bad_opcode = 1'b1;
    @(negedge clk);
    bad_opcode = 1'b0;
    rd(3'd4, d); chk("R7 intr", d, 16'h8000);
    rd(3'd3, d); chk("R7 status", d, 16'h0400);
    wr(3'd0, 16'h0013);
    chk("R5 refused after R7", {15'd0, cmd_go}, 16'h0000);

    // R3 / R4 sweep over AND masks
    for (int m = 0; m < 32; m++) begin
      logic [15:0] mask;
      mask = 16'h7F0F | (16'(m >> 4) << 15) | (16'(m & 15) << 4);
      load_all();
      wr(3'd4, mask);
      rd(3'd4, d); chk("R3 and mask", d, 16'h80E0 & mask);
      rd(3'd3, d); chk("R4 error clear", d, ((m >> 4) != 0) ? 16'h3C00 : 16'h0000);
    end

    // R11 same-cycle merge
    load_all();
    done_kind = 2'd2; done_err = 1'b0; done_pulse = 1'b1;
    wr(3'd4, 16'h0000);
    done_pulse = 1'b0;
    rd(3'd4, d); chk("R11 intr merge", d, 16'h8040);
    rd(3'd3, d); chk("R11 status merge", d, 16'h0000);
    load_all();
    done_kind = 2'd3; done_err = 1'b1; done_pulse = 1'b1;
    wr(3'd4, 16'h0000);
    done_pulse = 1'b0; done_err = 1'b0;
    rd(3'd4, d); chk("R11 intr merge err", d, 16'h8080);
    rd(3'd3, d); chk("R11 status merge err", d, 16'h2400);

    // R8 polarity sweep
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 2; b++) begin
        wr(3'd1, (p != 0) ? 16'h40C0 : 16'h4080);
        wr(3'd4, 16'h0000);
        if (b != 0) done(0, 1'b0);
        chk("R8 irq", {15'd0, irq}, 16'((b != 0) ^ (p == 0)));
      end
    end

    // R9 / R10 configuration sweep
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = 16'(i * 16'h2493) ^ 16'h5A1F;
      wr(3'd1, v);
      rd(3'd1, d); chk("R9 cfg1 masked", d, v & 16'hFFE0);
      chk("R10 rdy", {15'd0, rdy}, {15'd0, v[7]});
      wr(3'd2, ~v);
      rd(3'd2, d); chk("R9 cfg2 full", d, ~v);
    end

    // R12 writes to status and unused addresses
    load_all();
    rd(3'd0, snap_c); rd(3'd1, snap_1); rd(3'd2, snap_2); rd(3'd3, snap_s); rd(3'd4, snap_i);
    wr(3'd3, 16'h0000);
    for (int a = 5; a < 8; a++) wr(3'(a), 16'h0000);
    rd(3'd0, d); chk("R12 command kept", d, snap_c);
    rd(3'd1, d); chk("R12 cfg1 kept", d, snap_1);
    rd(3'd2, d); chk("R12 cfg2 kept", d, snap_2);
    rd(3'd3, d); chk("R12 status kept", d, 16'h3C00);
    rd(3'd4, d); chk("R12 intr kept", d, snap_i);

    // R2 warm reset, with a competing event in the same cycle
    wr(3'd1, 16'h0000);
    warm_rst = 1'b1; done_kind = 2'd1; done_err = 1'b1; done_pulse = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0; done_pulse = 1'b0; done_err = 1'b0;
    rd(3'd4, d); chk("R2 intr", d, 16'h8010);
    rd(3'd3, d); chk("R2 status", d, 16'h0000);
    rd(3'd0, d); chk("R2 command", d, 16'h0000);
    rd(3'd1, d); chk("R2 cfg1", d, 16'h40C0);
    rd(3'd2, d); chk("R2 cfg2", d, 16'h0000);
    chk("R2 rdy", {15'd0, rdy}, 16'h0001);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=%h exp=%h", 16'h0000, 16'h0001);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule